// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block gives the fetch stage a guess for the next instruction address before the current instruction has been decoded. It keeps a direct-mapped table of 2^IDX_W entries, indexed by word-address bits of the fetch PC. Each entry holds a valid flag, the complete PC of a control instruction as its tag, the last known destination of that instruction, and a 2-bit saturating confidence counter. A fetch PC that matches a valid tag and whose counter leans towards taken is redirected to the stored destination. Every other fetch PC, including any non-control instruction, continues to PC+4.

The execute stage resolves each instruction and returns it through the update port. The update carries the lookup result that travelled with the instruction down the pipeline: hit flag, counter and predicted next PC. Taken control instructions that missed are installed. Control instructions that hit have their counter stepped. A wrong guess also rewrites the entry's tag and destination, and a registered mispredict flag with the corrected PC tells the pipeline to squash the wrong-path work.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every lookup misses: `pred_hit` is 0, `pred_ctr` is 0 and `pred_npc` equals the looked-up PC plus 4.
- R2: Lookup results appear on the outputs one clock after `fetch_pc` is presented. The index is `fetch_pc[2 +: IDX_W]`.
- R3: On a hit, `pred_ctr` shows the entry's counter. Counter encoding: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. Bit 1 set means taken. A hit with bit 1 set gives the stored destination on `pred_npc`; a hit with bit 1 clear gives PC+4.
- R4: A PC that shares an index with a stored entry but differs from its tag misses and gets PC+4.
- R5: A control update (`upd_ctrl`=1) that was taken and carries `upd_hit`=0 installs the entry with tag `upd_pc`, destination `upd_target` and counter 3.
- R6: Updates with `upd_ctrl`=0 never change the table. Not-taken control updates that carry `upd_hit`=0 never change the table.
- R7: A control update that carries `upd_hit`=1 writes the carried counter plus one (saturating at 3) when taken, and minus one (saturating at 0) when not taken.
- R8: One clock after an update, `mispredict` is 1 exactly when the resolved next PC differs from `upd_pred_npc`. The resolved next PC is `upd_target` if `upd_taken` is 1, else `upd_pc`+4. `fix_pc` then holds the resolved next PC. `mispredict` is 0 in every cycle that follows no update.
- R9: A mispredicted control update that carries `upd_hit`=1 also rewrites the entry's destination with `upd_target`.
- R10: A lookup and an update that fall on the same index in the same cycle return the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_npc | output | PC_W | Predicted next PC for the previous cycle's fetch PC |
| pred_hit | output | 1 | Tag match on a valid entry |
| pred_ctr | output | 2 | Counter of the hit entry, 0 on miss |
| upd_vld | input | 1 | Resolved instruction present |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_ctrl | input | 1 | Instruction is a branch or jump |
| upd_taken | input | 1 | Control transfer was taken |
| upd_target | input | PC_W | Computed destination |
| upd_hit | input | 1 | Hit flag carried from lookup |
| upd_ctr | input | 2 | Counter carried from lookup |
| upd_pred_npc | input | PC_W | Predicted next PC carried from lookup |
| mispredict | output | 1 | Registered wrong-guess flag |
| fix_pc | output | PC_W | Corrected next PC |

## Verification
The hardest case to reach is a lookup and an update on the same index in the same cycle. Normal fetch order never makes them meet on purpose. The bench drives both ports deliberately in one cycle, once as a counter step on a live entry and once as an alias install that evicts a different tag. It then checks that the old contents came back first and the new contents a cycle later. Counter saturation at both ends is reached by repeating same-direction outcomes on one entry well past the limits.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'd0;
  localparam ctr_t CTR_STRONG_T  = 2'd3;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_STRONG_T)  ? c : c + 2'd1;
    else       r = (c == CTR_STRONG_NT) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_sdp_ram.sv
module btb_sdp_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/btb_valid_vec.sv
module btb_valid_vec #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic [AW-1:0] ra,
  output logic          rd
);
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rd    <= 1'b0;
    end else begin
      if (set_en) vld_q[set_idx] <= 1'b1;
      rd <= vld_q[ra];
    end
  end

  // R5
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> vld_q[$past(set_idx)]);
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IDX_W = 4,
  parameter int INSTR_BYTES = 4,
  localparam int OFF = $clog2(INSTR_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_vld,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_ctrl,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_hit,
  input  ctr_t            upd_ctr,
  input  logic [PC_W-1:0] upd_pred_npc,
  output logic            ent_we,
  output logic            ctr_we,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t            ctr_wd,
  output logic            mispredict,
  output logic [PC_W-1:0] fix_pc
);
  logic [PC_W-1:0] resolved_npc;
  logic            wrong;
  logic            ctrl_upd;

  always_comb begin
    resolved_npc = upd_taken ? upd_target : upd_pc + PC_W'(INSTR_BYTES);
    wrong        = upd_vld && (resolved_npc != upd_pred_npc);
    ctrl_upd     = upd_vld && upd_ctrl;
    wr_idx       = upd_pc[OFF +: IDX_W];
    ctr_we       = ctrl_upd && (upd_hit || upd_taken);
    ctr_wd       = upd_hit ? ctr_step(upd_ctr, upd_taken) : CTR_STRONG_T;
    ent_we       = ctrl_upd && (upd_hit ? wrong : upd_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict <= 1'b0;
      fix_pc     <= '0;
    end else begin
      mispredict <= wrong;
      fix_pc     <= resolved_npc;
    end
  end

  // R6
  noncontrol_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_vld && upd_ctrl) |-> !ent_we && !ctr_we);
  // R5
  install_strong_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr_we && !upd_hit) |-> ctr_wd == CTR_STRONG_T);
  // R7
  ctr_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr_we && upd_hit) |-> (ctr_wd == upd_ctr) || (ctr_wd == upd_ctr + 2'd1)
                            || (ctr_wd == upd_ctr - 2'd1));
  // R8
  mispredict_follows_update_chk: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(upd_vld));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            vld_rd,
  input  logic [PC_W-1:0] tag_rd,
  input  logic [PC_W-1:0] tgt_rd,
  input  ctr_t            ctr_rd,
  output logic [PC_W-1:0] pred_npc,
  output logic            pred_hit,
  output ctr_t            pred_ctr
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= fetch_pc;
  end

  always_comb begin
    pred_hit = vld_rd && (tag_rd == pc_q);
    pred_ctr = pred_hit ? ctr_rd : CTR_STRONG_NT;
    pred_npc = (pred_hit && ctr_says_taken(ctr_rd)) ? tgt_rd
                                                    : pc_q + PC_W'(INSTR_BYTES);
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IDX_W = 7,
  parameter int INSTR_BYTES = 4,
  localparam int DEPTH = 1 << IDX_W,
  localparam int OFF = $clog2(INSTR_BYTES),
  localparam int ENT_W = 2 * PC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  output logic            pred_hit,
  output logic [1:0]      pred_ctr,
  input  logic            upd_vld,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_ctrl,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_hit,
  input  logic [1:0]      upd_ctr,
  input  logic [PC_W-1:0] upd_pred_npc,
  output logic            mispredict,
  output logic [PC_W-1:0] fix_pc
);
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             ent_we, ctr_we;
  ctr_t             ctr_wd, ctr_rd;
  logic [ENT_W-1:0] ent_rd;
  logic             vld_rd;

  assign rd_idx = fetch_pc[OFF +: IDX_W];

  btb_update_ctl #(.PC_W(PC_W), .IDX_W(IDX_W), .INSTR_BYTES(INSTR_BYTES)) u_upd (
    .clk, .rst, .upd_vld, .upd_pc, .upd_ctrl, .upd_taken, .upd_target,
    .upd_hit, .upd_ctr, .upd_pred_npc,
    .ent_we, .ctr_we, .wr_idx, .ctr_wd, .mispredict, .fix_pc
  );

  btb_sdp_ram #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_ent_ram (
    .clk, .we(ent_we), .wa(wr_idx), .wd({upd_pc, upd_target}),
    .ra(rd_idx), .rd(ent_rd)
  );

  btb_sdp_ram #(.WIDTH(2), .DEPTH(DEPTH)) u_ctr_ram (
    .clk, .we(ctr_we), .wa(wr_idx), .wd(ctr_wd), .ra(rd_idx), .rd(ctr_rd)
  );

  btb_valid_vec #(.DEPTH(DEPTH)) u_vld (
    .clk, .rst, .set_en(ent_we), .set_idx(wr_idx), .ra(rd_idx), .rd(vld_rd)
  );

  btb_lookup #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_look (
    .clk, .rst, .fetch_pc, .vld_rd,
    .tag_rd(ent_rd[ENT_W-1:PC_W]), .tgt_rd(ent_rd[PC_W-1:0]), .ctr_rd,
    .pred_npc, .pred_hit, .pred_ctr
  );
endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int PW = 16;
  localparam int IW = 3;
  localparam int N  = 1 << IW;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [PW-1:0] fetch_pc, pred_npc, upd_pc, upd_target, upd_pred_npc, fix_pc;
  logic pred_hit, upd_vld, upd_ctrl, upd_taken, upd_hit, mispredict;
  logic [1:0] pred_ctr, upd_ctr;

  btb_predictor #(.PC_W(PW), .IDX_W(IW)) dut (
    .clk, .rst, .fetch_pc, .pred_npc, .pred_hit, .pred_ctr,
    .upd_vld, .upd_pc, .upd_ctrl, .upd_taken, .upd_target, .upd_hit,
    .upd_ctr, .upd_pred_npc, .mispredict, .fix_pc
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          mv   [N];
  logic [PW-1:0] mtag [N];
  logic [PW-1:0] mtgt [N];
  logic [1:0]    mctr [N];

  localparam logic [PW-1:0] BASE = 16'h0100;

  function automatic logic [PW-1:0] pc_of(input int i);
    return BASE + PW'(4 * i);
  endfunction
  function automatic logic [PW-1:0] tgt_of(input int i);
    return 16'h4000 + PW'(16'h100 * i);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_look(input logic [PW-1:0] pc, output logic h,
                            output logic [1:0] c, output logic [PW-1:0] npc);
    int i;
    i = int'(pc[2 +: IW]);
    h = mv[i] && (mtag[i] == pc);
    c = h ? mctr[i] : 2'd0;
    npc = (h && c[1]) ? mtgt[i] : pc + 16'd4;
  endtask

  task automatic cyc;
    @(posedge clk);
    #2;
  endtask

  // One cycle: lookup of lpc plus an optional update of upc.
  task automatic step(input logic [PW-1:0] lpc, input logic uv, input logic uctrl,
                      input logic utaken, input logic [PW-1:0] utgt,
                      input logic [PW-1:0] upc, input string req);
    logic eh, uh; logic [1:0] ec, uc; logic [PW-1:0] en, un, res;
    logic emis; int wi; logic [1:0] nc;
    model_look(lpc, eh, ec, en);
    model_look(upc, uh, uc, un);
    res  = utaken ? utgt : upc + 16'd4;
    emis = uv && (res != un);
    fetch_pc = lpc; upd_vld = uv; upd_pc = upc; upd_ctrl = uctrl;
    upd_taken = utaken; upd_target = utgt; upd_hit = uh; upd_ctr = uc;
    upd_pred_npc = un;
    cyc();
    chk(req, "pred_hit", 32'(pred_hit), 32'(eh));
    chk(req, "pred_ctr", 32'(pred_ctr), 32'(ec));
    chk(req, "pred_npc", 32'(pred_npc), 32'(en));
    chk(req, "mispredict R8", 32'(mispredict), 32'(emis));
    if (emis) chk(req, "fix_pc R8", 32'(fix_pc), 32'(res));
    wi = int'(upc[2 +: IW]);
    if (uv && uctrl) begin
      if (uh) begin
        nc = uc;
        if (utaken && nc != 2'd3) nc = nc + 2'd1;
        if (!utaken && nc != 2'd0) nc = nc - 2'd1;
        mctr[wi] = nc;
        if (emis) begin mtag[wi] = upc; mtgt[wi] = utgt; mv[wi] = 1'b1; end
      end else if (utaken) begin
        mv[wi] = 1'b1; mtag[wi] = upc; mtgt[wi] = utgt; mctr[wi] = 2'd3;
      end
    end
    upd_vld = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mtag[i] = 0; mtgt[i] = 0; mctr[i] = 0; end
    rst = 1'b1; fetch_pc = '0; upd_vld = 0; upd_pc = '0; upd_ctrl = 0;
    upd_taken = 0; upd_target = '0; upd_hit = 0; upd_ctr = '0; upd_pred_npc = '0;
    repeat (3) cyc();
    rst = 1'b0;
    // R1 R2: empty table after reset
    for (int i = 0; i < N; i++) step(pc_of(i), 0, 0, 0, '0, pc_of(i), "R1 R2");
    // R6: non-control and not-taken misses leave table empty
    for (int i = 0; i < N; i++) begin
      step(pc_of(i), 1, 0, 0, tgt_of(i), pc_of(i), "R6");
      step(pc_of(i), 1, 1, 0, tgt_of(i), pc_of(i), "R6");
      step(pc_of(i), 0, 0, 0, '0, pc_of(i), "R6");
    end
    // R5 R3: install taken and look up
    for (int i = 0; i < N; i++) begin
      step(pc_of(i), 1, 1, 1, tgt_of(i), pc_of(i), "R5");
      step(pc_of(i), 0, 0, 0, '0, pc_of(i), "R5 R3");
    end
    // R4: aliasing PCs miss
    for (int i = 0; i < N; i++) step(pc_of(i) + PW'(4 * N), 0, 0, 0, '0, '0, "R4");
    // R7 R9 R3: walk counter of entry 0 past both ends
    for (int k = 0; k < 3; k++) step(pc_of(0), 1, 1, 1, tgt_of(0), pc_of(0), "R7");
    for (int k = 0; k < 5; k++) step(pc_of(0), 1, 1, 0, tgt_of(0), pc_of(0), "R7 R9 R3");
    for (int k = 0; k < 5; k++) step(pc_of(0), 1, 1, 1, tgt_of(0), pc_of(0), "R7 R9 R3");
    step(pc_of(0), 0, 0, 0, '0, '0, "R7");
    // R9: jump to a new destination rewrites target
    step(pc_of(1), 1, 1, 1, 16'h7770, pc_of(1), "R9 R8");
    step(pc_of(1), 0, 0, 0, '0, '0, "R9");
    // R6 R8: non-control at a hit entry flags but does not write
    step(pc_of(7), 1, 0, 0, '0, pc_of(7), "R6 R8");
    step(pc_of(7), 0, 0, 0, '0, '0, "R6");
    // R10: same-index lookup and update
    step(pc_of(5), 1, 1, 0, tgt_of(5), pc_of(5), "R10");
    step(pc_of(5), 0, 0, 0, '0, '0, "R10 R7");
    step(pc_of(6), 1, 1, 1, 16'h5550, pc_of(6) + PW'(4 * N), "R10");
    step(pc_of(6), 0, 0, 0, '0, '0, "R4 R10");
    step(pc_of(6) + PW'(4 * N), 0, 0, 0, '0, '0, "R5 R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule